// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Unit

This block turns a fixed-point angle, given in radians, into its sine and cosine. It uses a chain of CORDIC micro-rotations in rotation mode, with one register per rotation. A new angle can enter on every advancing clock. A valid flag travels alongside each sample, so empty slots in the input stream come out as empty slots. The start vector is preloaded with the inverse of the rotation gain, so the results need no scaling afterwards.

A parameter picks one of two formats. The signed form takes an angle anywhere in the full circle. It folds angles beyond a quarter turn back by half a turn and flips both results at the end. The unsigned form covers only the first quadrant and gives non-negative results. A second parameter decides whether the clock-enable pin does anything. The reset is asynchronous.

Top module: `cordic_sincos`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly F_OUT+3 advancing clocks later: one input register, F_OUT+1 rotation stages and one output register. An input slot with `in_valid` low comes out with `out_valid` low.
- R2: Signed form (SIGNED_MODE=1). `angle` is two's complement, F_IN+3 bits wide, with F_IN fraction bits, and lies in [-pi, +pi]. `sin_o` and `cos_o` are two's complement, F_OUT+2 bits wide, with F_OUT fraction bits. Each is within 3 LSB of the true value rounded to F_OUT fraction bits.
- R3: In the signed form, an angle whose magnitude exceeds pi/2 gives results with the correct quadrant signs. Cosine is negative there, and sine takes the sign of the angle.
- R4: Unsigned form (SIGNED_MODE=0). `angle` is unsigned, F_IN+1 bits wide, with F_IN fraction bits, and lies in [0, pi/2]. Both outputs are unsigned, F_OUT+1 bits wide, with F_OUT fraction bits, and within 3 LSB of the rounded true value.
- R5: Outputs are clamped so that no code exceeds +1.0 (2^F_OUT). Signed results never fall below -1.0. Unsigned results never fall below zero. At angle 0, the cosine lies in [2^F_OUT-3, 2^F_OUT].
- R6: With HAS_EN=1 and `en` low, every pipeline register holds its value, so `out_valid`, `sin_o` and `cos_o` stay frozen. An angle offered while `en` is low is dropped.
- R7: Raising `areset` clears `out_valid`, `sin_o` and `cos_o` to zero at once, without waiting for a clock edge.
- R8: In the signed form, the codes nearest to +pi and to -pi give a cosine within 3 LSB above -1.0 and a sine within 3 LSB of zero.
- R9: With HAS_EN=0, `en` is ignored and the pipeline advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| areset | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Clock enable; used only when HAS_EN=1 |
| in_valid | input | 1 | Marks `angle` as a sample to process |
| angle | input | F_IN+3 (signed) or F_IN+1 (unsigned) | Angle in radians, fixed point |
| out_valid | output | 1 | Marks `sin_o`/`cos_o` as a result |
| sin_o | output | F_OUT+2 (signed) or F_OUT+1 (unsigned) | Sine of the angle |
| cos_o | output | F_OUT+2 (signed) or F_OUT+1 (unsigned) | Cosine of the angle |

## Verification
The bench builds two copies, both with F_IN=F_OUT=12. The first uses the signed full-circle form with the enable pin active. The second uses the unsigned quadrant form with the enable pin disabled. Between them, the bench reaches both folding branches, both saturation branches, and the enable-ignored path, while driving the same enable signal into both copies. The ±pi endpoints, a zero angle that pushes the cosine against the clamp, and stretches of random enable stalls are all within reach, and a behavioural delay-line model checks each of them on every clock.

// File: rtl/cordic_sc_pkg.sv
package cordic_sc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam real PI_R = 3.14159265358979323846;

   // 2**e as a real, e >= 0
   function automatic real pow2(input int e);
      real r;
      r = 1.0;
      for (int k = 0; k < e; k++) r = r * 2.0;
      return r;
   endfunction

   // arctan(2**-i) by power series (i >= 1), exact constant for i = 0
   function automatic real atan_pow2(input int i);
      real x;
      real xp;
      real acc;
      if (i == 0) return PI_R / 4.0;
      x   = 1.0 / pow2(i);
      xp  = x;
      acc = 0.0;
      for (int k = 0; k < 40; k++) begin
         if ((k % 2) == 0) acc = acc + xp / real'(2 * k + 1);
         else              acc = acc - xp / real'(2 * k + 1);
         xp = xp * x * x;
      end
      return acc;
   endfunction

   // 1/K for n micro-rotations: 1/sqrt(prod(1 + 2**-2k))
   function automatic real inv_gain(input int n);
      real p;
      real g;
      p = 1.0;
      for (int k = 0; k < n; k++) p = p * (1.0 + 1.0 / pow2(2 * k));
      g = p;
      for (int k = 0; k < 60; k++) g = 0.5 * (g + p / g);
      return 1.0 / g;
   endfunction

   // round a real to a fixed-point code with fw fraction bits
   function automatic longint fix(input real v, input int fw);
      real s;
      s = v * pow2(fw);
      if (s >= 0.0) return longint'($rtoi(s + 0.5));
      else          return -longint'($rtoi(-s + 0.5));
   endfunction
endpackage

// File: rtl/cordic_sc_fold.sv
module cordic_sc_fold
   import cordic_sc_pkg::*;
#(
   parameter int F_IN        = 14,
   parameter int FW          = 18,
   parameter int SIGNED_MODE = 1,
   parameter int AW          = 17,
   parameter int ZW          = 21
) (
   input  logic                 clk,
   input  logic                 areset,
   input  logic                 adv,
   input  logic                 i_valid,
   input  logic [AW-1:0]        i_angle,
   output logic                 o_valid,
   output logic                 o_neg,
   output logic signed [ZW-1:0] o_z
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int TW  = ZW + AW;
   localparam int LSH = (FW >= F_IN) ? (FW - F_IN) : 0;
   localparam int RSH = (FW >= F_IN) ? 0 : (F_IN - FW);
   localparam logic signed [ZW-1:0] PI_C   = ZW'(fix(PI_R, FW));
   localparam logic signed [ZW-1:0] HALF_C = ZW'(fix(PI_R / 2.0, FW));

   logic signed [ZW-1:0] z_al;
   logic signed [ZW-1:0] z_f;
   logic                 neg_f;

   generate
      if (SIGNED_MODE != 0) begin : g_signed
         always_comb begin
            z_al  = ZW'((TW'($signed(i_angle)) <<< LSH) >>> RSH);
            z_f   = z_al;
            neg_f = 1'b0;
            if (z_al > HALF_C) begin
               z_f   = z_al - PI_C;
               neg_f = 1'b1;
            end else if (z_al < -HALF_C) begin
               z_f   = z_al + PI_C;
               neg_f = 1'b1;
            end
         end

         // folded angle always lands inside the quarter-turn band
         p_fold_range_r3 : assert property (@(posedge clk) disable iff (areset)
            o_valid |-> ((o_z <= HALF_C + 2) && (o_z >= -HALF_C - 2)));
      end else begin : g_unsigned
         always_comb begin
            z_al  = ZW'((TW'($signed({1'b0, i_angle})) <<< LSH) >>> RSH);
            z_f   = z_al;
            neg_f = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge areset) begin
      if (areset) begin
         o_valid <= 1'b0;
         o_neg   <= 1'b0;
         o_z     <= '0;
      end else if (adv) begin
         o_valid <= i_valid;
         o_neg   <= neg_f;
         o_z     <= z_f;
      end
   end
endmodule

// File: rtl/cordic_sc_stage.sv
module cordic_sc_stage
   import cordic_sc_pkg::*;
#(
   parameter int IDX = 0,
   parameter int FW  = 18,
   parameter int XW  = 21,
   parameter int ZW  = 21
) (
   input  logic                 clk,
   input  logic                 areset,
   input  logic                 adv,
   input  logic                 i_valid,
   input  logic                 i_neg,
   input  logic signed [XW-1:0] i_x,
   input  logic signed [XW-1:0] i_y,
   input  logic signed [ZW-1:0] i_z,
   output logic                 o_valid,
   output logic                 o_neg,
   output logic signed [XW-1:0] o_x,
   output logic signed [XW-1:0] o_y,
   output logic signed [ZW-1:0] o_z
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic signed [ZW-1:0] ANG_C = ZW'(fix(atan_pow2(IDX), FW));

   logic signed [XW-1:0] x_n;
   logic signed [XW-1:0] y_n;
   logic signed [ZW-1:0] z_n;

   always_comb begin
      if (!i_z[ZW-1]) begin
         x_n = i_x - (i_y >>> IDX);
         y_n = i_y + (i_x >>> IDX);
         z_n = i_z - ANG_C;
      end else begin
         x_n = i_x + (i_y >>> IDX);
         y_n = i_y - (i_x >>> IDX);
         z_n = i_z + ANG_C;
      end
   end

   always_ff @(posedge clk or posedge areset) begin
      if (areset) begin
         o_valid <= 1'b0;
         o_neg   <= 1'b0;
         o_x     <= '0;
         o_y     <= '0;
         o_z     <= '0;
      end else if (adv) begin
         o_valid <= i_valid;
         o_neg   <= i_neg;
         o_x     <= x_n;
         o_y     <= y_n;
         o_z     <= z_n;
      end
   end

   // the valid flag moves one stage per advancing clock
   p_valid_step_r1 : assert property (@(posedge clk) disable iff (areset)
      adv |=> (o_valid == $past(i_valid)));
endmodule

// File: rtl/cordic_sc_out.sv
module cordic_sc_out #(
   parameter int F_OUT       = 14,
   parameter int GUARD       = 4,
   parameter int XW          = 21,
   parameter int SIGNED_MODE = 1,
   parameter int OW          = 16
) (
   input  logic                 clk,
   input  logic                 areset,
   input  logic                 adv,
   input  logic                 i_valid,
   input  logic                 i_neg,
   input  logic signed [XW-1:0] i_x,
   input  logic signed [XW-1:0] i_y,
   output logic                 o_valid,
   output logic [OW-1:0]        o_sin,
   output logic [OW-1:0]        o_cos
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic signed [XW-1:0] RND_C = XW'(longint'(1) <<< (GUARD - 1));
   localparam logic signed [XW-1:0] ONE_C = XW'(longint'(1) <<< F_OUT);
   localparam logic signed [XW-1:0] LO_C  = (SIGNED_MODE != 0) ? -ONE_C : XW'(0);
   localparam logic signed [OW-1:0] ONE_O = OW'(longint'(1) <<< F_OUT);

   function automatic logic [OW-1:0] shape(input logic signed [XW-1:0] v, input logic ng);
      logic signed [XW-1:0] r;
      r = (v + RND_C) >>> GUARD;
      if (ng) r = -r;
      if (r > ONE_C)     r = ONE_C;
      else if (r < LO_C) r = LO_C;
      return OW'(r);
   endfunction

   always_ff @(posedge clk or posedge areset) begin
      if (areset) begin
         o_valid <= 1'b0;
         o_sin   <= '0;
         o_cos   <= '0;
      end else if (adv) begin
         o_valid <= i_valid;
         o_sin   <= shape(i_y, i_neg);
         o_cos   <= shape(i_x, i_neg);
      end
   end

   generate
      if (SIGNED_MODE != 0) begin : g_chk_signed
         p_sat_sgn_r5 : assert property (@(posedge clk) disable iff (areset)
            o_valid |-> (($signed(o_sin) <= ONE_O) && ($signed(o_sin) >= -ONE_O) &&
                         ($signed(o_cos) <= ONE_O) && ($signed(o_cos) >= -ONE_O)));
      end else begin : g_chk_unsigned
         p_sat_uns_r5 : assert property (@(posedge clk) disable iff (areset)
            o_valid |-> (($unsigned(o_sin) <= $unsigned(ONE_O)) &&
                         ($unsigned(o_cos) <= $unsigned(ONE_O))));
      end
   endgenerate
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
   import cordic_sc_pkg::*;
#(
   parameter int F_IN        = 14,
   parameter int F_OUT       = 14,
   parameter int SIGNED_MODE = 1,
   parameter int HAS_EN      = 1,
   parameter int GUARD       = 4
) (
   input  logic                                                clk,
   input  logic                                                areset,
   input  logic                                                en,
   input  logic                                                in_valid,
   input  logic [F_IN + ((SIGNED_MODE != 0) ? 3 : 1) - 1:0]    angle,
   output logic                                                out_valid,
   output logic [F_OUT + ((SIGNED_MODE != 0) ? 2 : 1) - 1:0]   sin_o,
   output logic [F_OUT + ((SIGNED_MODE != 0) ? 2 : 1) - 1:0]   cos_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW  = F_IN + ((SIGNED_MODE != 0) ? 3 : 1);
   localparam int OW  = F_OUT + ((SIGNED_MODE != 0) ? 2 : 1);
   localparam int FW  = F_OUT + GUARD;
   localparam int ZW  = FW + 3;
   localparam int XW  = FW + 3;
   localparam int NST = F_OUT + 1;
   localparam logic signed [XW-1:0] INVK_C = XW'(fix(inv_gain(NST), FW));
   localparam logic signed [ZW-1:0] RES_C  =
      ZW'(fix(atan_pow2(NST - 1), FW) + longint'(NST) + 2);

   // elaboration-time parameter checks
   generate
      if (F_IN < 2 || F_IN > 24) begin : g_bad_fin
         $error("cordic_sincos: F_IN must lie in 2..24");
      end
      if (F_OUT < 2 || F_OUT > 24) begin : g_bad_fout
         $error("cordic_sincos: F_OUT must lie in 2..24");
      end
      if (GUARD < 1 || GUARD > 4) begin : g_bad_guard
         $error("cordic_sincos: GUARD must lie in 1..4");
      end
      if (SIGNED_MODE != 0 && SIGNED_MODE != 1) begin : g_bad_mode
         $error("cordic_sincos: SIGNED_MODE must be 0 or 1");
      end
      if (HAS_EN != 0 && HAS_EN != 1) begin : g_bad_en
         $error("cordic_sincos: HAS_EN must be 0 or 1");
      end
   endgenerate

   logic adv;
   generate
      if (HAS_EN != 0) begin : g_en
         assign adv = en;
      end else begin : g_free
         assign adv = 1'b1;
      end
   endgenerate

   logic                 pv [NST+1];
   logic                 pn [NST+1];
   logic signed [XW-1:0] px [NST+1];
   logic signed [XW-1:0] py [NST+1];
   logic signed [ZW-1:0] pz [NST+1];

   cordic_sc_fold #(
      .F_IN(F_IN), .FW(FW), .SIGNED_MODE(SIGNED_MODE), .AW(AW), .ZW(ZW)
   ) u_fold (
      .clk(clk), .areset(areset), .adv(adv),
      .i_valid(in_valid), .i_angle(angle),
      .o_valid(pv[0]), .o_neg(pn[0]), .o_z(pz[0])
   );

   assign px[0] = INVK_C;
   assign py[0] = '0;

   generate
      for (genvar k = 0; k < NST; k++) begin : g_stage
         cordic_sc_stage #(
            .IDX(k), .FW(FW), .XW(XW), .ZW(ZW)
         ) u_rot (
            .clk(clk), .areset(areset), .adv(adv),
            .i_valid(pv[k]), .i_neg(pn[k]),
            .i_x(px[k]), .i_y(py[k]), .i_z(pz[k]),
            .o_valid(pv[k+1]), .o_neg(pn[k+1]),
            .o_x(px[k+1]), .o_y(py[k+1]), .o_z(pz[k+1])
         );
      end
   endgenerate

   cordic_sc_out #(
      .F_OUT(F_OUT), .GUARD(GUARD), .XW(XW), .SIGNED_MODE(SIGNED_MODE), .OW(OW)
   ) u_out (
      .clk(clk), .areset(areset), .adv(adv),
      .i_valid(pv[NST]), .i_neg(pn[NST]),
      .i_x(px[NST]), .i_y(py[NST]),
      .o_valid(out_valid), .o_sin(sin_o), .o_cos(cos_o)
   );

   // residual angle after the last rotation has converged
   p_resid_r2 : assert property (@(posedge clk) disable iff (areset)
      pv[NST] |-> ((pz[NST] <= RES_C) && (pz[NST] >= -RES_C)));

   // a stalled pipeline keeps its outputs
   p_hold_r6 : assert property (@(posedge clk) disable iff (areset)
      !adv |=> ($stable(out_valid) && $stable(sin_o) && $stable(cos_o)));
endmodule

// File: tb/sim_cordic_sincos.sv
module sim_cordic_sincos;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int  FI   = 12;
   localparam int  FO   = 12;
   localparam int  LAT  = FO + 3;
   localparam int  TOL  = 3;
   localparam int  ONE  = 1 << FO;
   localparam int  AW0  = FI + 3;
   localparam int  AW1  = FI + 1;
   localparam real PI_V = 3.14159265358979323846;

   logic           clk = 1'b0;
   logic           areset = 1'b1;
   logic           en = 1'b1;
   logic           vin = 1'b0;
   logic [AW0-1:0] ang0 = '0;
   logic [AW1-1:0] ang1 = '0;
   logic           ov0, ov1;
   logic [FO+1:0]  s0, c0;
   logic [FO:0]    s1, c1;

   int total = 0;
   int bad   = 0;
   bit live  = 1'b0;

   always #2 clk = ~clk;

   cordic_sincos #(.F_IN(FI), .F_OUT(FO), .SIGNED_MODE(1), .HAS_EN(1)) u0 (
      .clk(clk), .areset(areset), .en(en), .in_valid(vin), .angle(ang0),
      .out_valid(ov0), .sin_o(s0), .cos_o(c0));

   cordic_sincos #(.F_IN(FI), .F_OUT(FO), .SIGNED_MODE(0), .HAS_EN(0)) u1 (
      .clk(clk), .areset(areset), .en(en), .in_valid(vin), .angle(ang1),
      .out_valid(ov1), .sin_o(s1), .cos_o(c1));

   // behavioural delay-line model of both copies
   bit  mv0 [LAT];
   real ma0 [LAT];
   bit  mv1 [LAT];
   real ma1 [LAT];

   always @(posedge clk or posedge areset) begin
      if (areset) begin
         for (int k = 0; k < LAT; k++) begin
            mv0[k] = 1'b0; ma0[k] = 0.0;
            mv1[k] = 1'b0; ma1[k] = 0.0;
         end
      end else begin
         if (en) begin
            for (int k = LAT - 1; k > 0; k--) begin
               mv0[k] = mv0[k-1]; ma0[k] = ma0[k-1];
            end
            mv0[0] = vin;
            ma0[0] = real'($signed(ang0)) / real'(1 << FI);
         end
         for (int k = LAT - 1; k > 0; k--) begin
            mv1[k] = mv1[k-1]; ma1[k] = ma1[k-1];
         end
         mv1[0] = vin;
         ma1[0] = real'(ang1) / real'(1 << FI);
      end
   end

   function automatic int expv(input real v, input bit uns);
      real s;
      int  r;
      s = v * real'(ONE);
      r = (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
      if (r > ONE) r = ONE;
      if (uns && r < 0) r = 0;
      if (!uns && r < -ONE) r = -ONE;
      return r;
   endfunction

   function automatic int cd(input real a);
      real s;
      s = a * real'(1 << FI);
      return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (live && !areset) begin
         int e;
         int a;
         chk(ov0 == mv0[LAT-1], "R1 u0 valid", int'(ov0), int'(mv0[LAT-1]));
         chk(ov1 == mv1[LAT-1], "R1 u1 valid", int'(ov1), int'(mv1[LAT-1]));
         if (mv0[LAT-1]) begin
            e = expv($sin(ma0[LAT-1]), 1'b0); a = int'($signed(s0));
            chk(iabs(a - e) <= TOL, "R2 u0 sin", a, e);
            e = expv($cos(ma0[LAT-1]), 1'b0); a = int'($signed(c0));
            chk(iabs(a - e) <= TOL, "R2 u0 cos", a, e);
         end
         if (mv1[LAT-1]) begin
            e = expv($sin(ma1[LAT-1]), 1'b1); a = int'(s1);
            chk(iabs(a - e) <= TOL, "R4 u1 sin", a, e);
            e = expv($cos(ma1[LAT-1]), 1'b1); a = int'(c1);
            chk(iabs(a - e) <= TOL, "R4 u1 cos", a, e);
         end
      end
   end

   // single sample, then wait until it reaches the outputs
   task automatic shot(input int a0, input int a1);
      vin  = 1'b1;
      ang0 = AW0'(a0);
      ang1 = AW1'(a1);
      @(negedge clk);
      vin = 1'b0;
      repeat (LAT - 1) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(1'b0, "R1 watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int hs0, hc0;
      bit hv0;
      int a;
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(ov0 == 1'b0 && s0 == '0 && c0 == '0, "R7 u0 reset", int'(c0), 0);
      chk(ov1 == 1'b0 && s1 == '0 && c1 == '0, "R7 u1 reset", int'(c1), 0);
      areset = 1'b0;
      live   = 1'b1;
      @(negedge clk);

      // R5 angle zero
      shot(0, 0);
      a = int'($signed(c0));
      chk(a <= ONE && a >= ONE - TOL, "R5 u0 cos(0) clamp", a, ONE);
      a = int'(c1);
      chk(a <= ONE && a >= ONE - TOL, "R5 u1 cos(0) clamp", a, ONE);
      chk(int'(s1) <= TOL, "R5 u1 sin(0) not negative", int'(s1), 0);
      @(negedge clk);
      chk(ov0 == 1'b0 && ov1 == 1'b0, "R1 bubble after sample", int'(ov0), 0);

      // R8 +pi, R4 pi/2
      shot(cd(PI_V), cd(PI_V / 2.0));
      a = int'($signed(c0));
      chk(a >= -ONE && a <= -ONE + TOL, "R8 cos(+pi)", a, -ONE);
      a = int'($signed(s0));
      chk(iabs(a) <= TOL, "R8 sin(+pi)", a, 0);
      a = int'(s1);
      chk(a <= ONE && a >= ONE - TOL, "R4 sin(pi/2)", a, ONE);
      chk(int'(c1) <= TOL, "R4 cos(pi/2)", int'(c1), 0);

      // R8 -pi
      shot(cd(-PI_V), cd(0.5));
      a = int'($signed(c0));
      chk(a >= -ONE && a <= -ONE + TOL, "R8 cos(-pi)", a, -ONE);
      a = int'($signed(s0));
      chk(iabs(a) <= TOL, "R8 sin(-pi)", a, 0);

      // R3 folded quadrants
      shot(cd(2.5), cd(1.0));
      a = int'($signed(c0));
      chk(a < 0 && iabs(a - expv($cos(2.5), 1'b0)) <= TOL, "R3 cos(2.5)", a, expv($cos(2.5), 1'b0));
      chk(int'($signed(s0)) > 0, "R3 sin(2.5) sign", int'($signed(s0)), expv($sin(2.5), 1'b0));
      shot(cd(-2.0), cd(0.2));
      chk(int'($signed(c0)) < 0, "R3 cos(-2.0) sign", int'($signed(c0)), expv($cos(-2.0), 1'b0));
      a = int'($signed(s0));
      chk(a < 0 && iabs(a - expv($sin(-2.0), 1'b0)) <= TOL, "R3 sin(-2.0)", a, expv($sin(-2.0), 1'b0));

      // R6 freeze with en low, R9 en ignored on the free-running copy
      for (int k = 0; k < 6; k++) begin
         vin  = 1'b1;
         ang0 = AW0'(int'($urandom_range(0, 2 * cd(PI_V))) - cd(PI_V));
         ang1 = AW1'($urandom_range(0, cd(PI_V / 2.0)));
         @(negedge clk);
      end
      vin = 1'b0;
      repeat (LAT - 4) @(negedge clk);
      en   = 1'b0;
      vin  = 1'b1;
      ang0 = AW0'(cd(1.0));
      ang1 = AW1'(cd(0.3));
      @(negedge clk);
      vin = 1'b0;
      hv0 = ov0; hs0 = int'(s0); hc0 = int'(c0);
      repeat (LAT - 1) @(negedge clk);
      chk(ov0 == hv0 && int'(s0) == hs0 && int'(c0) == hc0, "R6 outputs frozen", int'(c0), hc0);
      chk(ov1 == 1'b1, "R9 en ignored, sample emerged", int'(ov1), 1);
      a = int'(s1);
      chk(iabs(a - expv($sin(0.3), 1'b1)) <= TOL, "R9 sin(0.3)", a, expv($sin(0.3), 1'b1));
      en = 1'b1;
      repeat (LAT + 2) @(negedge clk);

      // random stream with stalls
      for (int k = 0; k < 1500; k++) begin
         vin  = ($urandom_range(0, 9) < 7);
         en   = ($urandom_range(0, 9) < 8);
         ang0 = AW0'(int'($urandom_range(0, 2 * cd(PI_V))) - cd(PI_V));
         ang1 = AW1'($urandom_range(0, cd(PI_V / 2.0)));
         @(negedge clk);
      end

      // R7 asynchronous reset mid-stream
      en  = 1'b1;
      vin = 1'b1;
      repeat (LAT + 3) @(negedge clk);
      #1;
      areset = 1'b1;
      #0.5;
      chk(ov0 == 1'b0 && s0 == '0 && c0 == '0, "R7 u0 async clear", int'(ov0), 0);
      chk(ov1 == 1'b0 && s1 == '0 && c1 == '0, "R7 u1 async clear", int'(ov1), 0);
      vin = 1'b0;
      @(negedge clk);
      areset = 1'b0;

      for (int k = 0; k < 300; k++) begin
         vin  = ($urandom_range(0, 9) < 5);
         ang0 = AW0'(int'($urandom_range(0, 2 * cd(PI_V))) - cd(PI_V));
         ang1 = AW1'($urandom_range(0, cd(PI_V / 2.0)));
         @(negedge clk);
      end
      vin = 1'b0;
      repeat (LAT + 2) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule